// File: doc/BRIEF.md
# Dual-Clock FIFO with Handshake Pointer Transfer

This block moves data words from a producer clocked by `wr_clk` to a consumer clocked by `rd_clk`. The two clocks have no fixed relation. Each side has its own asynchronous active-low reset. For a clean start, both resets are applied together. Storage is a plain array of `DEPTH` words of `DW` bits. `DEPTH` is a power of two and at least 2.

Each domain keeps its own pointer. To give the other domain a copy, it takes a snapshot of that pointer in a register, which stays stable during the transfer. A level request/acknowledge exchange then carries the snapshot across in four phases. Each control line passes through a two-flop synchronizer. Gray coding is not used.

Each side computes its flags from its own live pointer and the last copy it has received of the remote pointer. A local access therefore raises a flag on the next edge of its own clock. A flag that is cleared by remote activity clears only after the next copy arrives.

A parameter sets the read port type. It is either registered or combinational, and the combinational port shows the head word one read clock earlier. The two almost-flag thresholds are runtime inputs. The caller must keep each threshold steady in, or registered into, the domain that uses it. The block does not detect illegal accesses: a write while full and a read while empty are the caller's responsibility.

Top module: `dcf_top`

## Requirements
- R1: While either reset is low, and just after both resets are released, `rd_empty` is 1 and `rd_almost_empty`, `wr_full`, `wr_almost_full` are 0.
- R2: Words leave in the order they were written, with their values intact, including after the pointers wrap past `DEPTH`.
- R3: A write that fills the last free slot sets `wr_full` at the very next `wr_clk` rising edge.
- R4: A read that removes the last stored word sets `rd_empty` at the very next `rd_clk` rising edge.
- R5: When a read frees a slot of a full FIFO, `wr_full` is still 1 at the first falling `wr_clk` after that read. It clears within 12 `wr_clk` cycles.
- R6: After a write into an empty FIFO, `rd_empty` is still 1 at the first falling `rd_clk` after that write. It clears within 12 `rd_clk` cycles.
- R7: Once settled, `wr_almost_full` is 1 exactly when the free slots (DEPTH minus stored words) are fewer than `wr_afull_lvl` and the FIFO is not full.
- R8: Once settled, `rd_almost_empty` is 1 exactly when the stored words are fewer than `rd_aempty_lvl` and the FIFO is not empty.
- R9: With `RD_MODE = RD_REG`, the word popped at a `rd_clk` edge with `rd_en` = 1 appears on `rd_data` after that edge. With `RD_MODE = RD_COMB`, `rd_data` shows the head word before `rd_en` is raised.
- R10: Writes on every `wr_clk` and reads on every `rd_clk`, each gated only by its own flag, run at the same time with no loss, no duplication and no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Asynchronous active-low reset for the write domain |
| wr_en | input | 1 | Push `wr_data` at this rising edge |
| wr_data | input | DW | Word to store |
| wr_afull_lvl | input | $clog2(DEPTH)+1 | Free-slot threshold for `wr_almost_full` |
| wr_full | output | 1 | No free slot (write domain) |
| wr_almost_full | output | 1 | Fewer free slots than threshold, not full |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Asynchronous active-low reset for the read domain |
| rd_en | input | 1 | Pop the head word at this rising edge |
| rd_aempty_lvl | input | $clog2(DEPTH)+1 | Stored-word threshold for `rd_almost_empty` |
| rd_data | output | DW | Read data (registered or combinational, per `RD_MODE`) |
| rd_empty | output | 1 | No stored word (read domain) |
| rd_almost_empty | output | 1 | Fewer stored words than threshold, not empty |

## Verification
A received pointer copy that is stale in the unsafe direction, or a snapshot that changes during a transfer, shows up at once at the ports. `rd_empty` drops while the head slot is still unwritten, so the next pop returns an old word. Or `wr_full` drops early, and the following write overwrites an unread word, which appears as a data mismatch several reads later.

A handshake that stalls shows up differently. A flag stays set after the remote side has moved, and the bench sees this as `wr_full` or `rd_empty` failing to clear within the 12-cycle window. A wrong occupancy calculation breaks the almost-flags or the full/empty flags at the next settled flag check.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;
    // Read port type of the storage array.
    typedef enum logic {
        RD_COMB = 1'b0,
        RD_REG  = 1'b1
    } rd_mode_e;

    // Flops per synchronizer chain on every handshake control line.
    localparam int unsigned DCF_SYNC_STAGES = 2;
endpackage

// File: rtl/dcf_sync.sv
`timescale 1ns/1ps
module dcf_sync #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    import dcf_pkg::*;

    localparam int unsigned LAST = DCF_SYNC_STAGES - 1;

    logic [W-1:0] stg_q [DCF_SYNC_STAGES];
    logic [W-1:0] stg_d [DCF_SYNC_STAGES];

    always_comb begin
        stg_d[0] = d;
        for (int i = 1; i < DCF_SYNC_STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DCF_SYNC_STAGES; i++) begin
                stg_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DCF_SYNC_STAGES; i++) begin
                stg_q[i] <= stg_d[i];
            end
        end
    end

    assign q = stg_q[LAST];
endmodule

// File: rtl/dcf_ram.sv
`timescale 1ns/1ps
module dcf_ram #(
    parameter int unsigned       DW      = 8,
    parameter int unsigned       DEPTH   = 8,
    parameter dcf_pkg::rd_mode_e RD_MODE = dcf_pkg::RD_REG,
    localparam int unsigned      AW      = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic          rrst_n,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    import dcf_pkg::*;

    logic [DW-1:0] mem_q [DEPTH];

    // Storage is written only in the write domain; no reset on the array.
    always_ff @(posedge wclk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    generate
        if (RD_MODE == RD_REG) begin : g_reg
            logic [DW-1:0] rdata_q, rdata_d;

            always_comb begin
                rdata_d = rdata_q;
                if (re) begin
                    rdata_d = mem_q[raddr];
                end
            end

            always_ff @(posedge rclk or negedge rrst_n) begin
                if (!rrst_n) begin
                    rdata_q <= '0;
                end else begin
                    rdata_q <= rdata_d;
                end
            end

            assign rdata = rdata_q;
        end else begin : g_comb
            assign rdata = mem_q[raddr];
        end
    endgenerate
endmodule

// File: rtl/dcf_top.sv
`timescale 1ns/1ps
module dcf_top #(
    parameter int unsigned       DW      = 8,
    parameter int unsigned       DEPTH   = 8,
    parameter dcf_pkg::rd_mode_e RD_MODE = dcf_pkg::RD_REG,
    localparam int unsigned      AW      = $clog2(DEPTH),
    localparam int unsigned      PW      = AW + 1
) (
    input  logic          wr_clk,
    input  logic          wr_rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic [PW-1:0] wr_afull_lvl,
    output logic          wr_full,
    output logic          wr_almost_full,
    input  logic          rd_clk,
    input  logic          rd_rst_n,
    input  logic          rd_en,
    input  logic [PW-1:0] rd_aempty_lvl,
    output logic [DW-1:0] rd_data,
    output logic          rd_empty,
    output logic          rd_almost_empty
);
    localparam logic [PW-1:0] CAP = PW'(DEPTH);
    localparam logic [PW-1:0] ONE = PW'(1);

    // Per-domain state. ptr: local pointer (one wrap bit above the address).
    // snap: stable copy offered to the other side while req is high.
    // copy: last pointer value received from the other side.
    // ack: this side's answer to the other side's request.
    // flag: full (write side) or empty (read side); almost: threshold flag.
    typedef struct packed {
        logic [PW-1:0] ptr;
        logic [PW-1:0] snap;
        logic [PW-1:0] copy;
        logic          req;
        logic          ack;
        logic          flag;
        logic          almost;
    } dom_t;

    dom_t w_q, w_d, r_q, r_d;

    logic          w_req_s, w_ack_s;  // read-side req/ack seen in write domain
    logic          r_req_s, r_ack_s;  // write-side req/ack seen in read domain
    logic [PW-1:0] w_used, w_free, r_used;

    // Plain views of the state for the bound checker.
    logic [PW-1:0] w_ptr, w_rcopy, w_snap, r_ptr, r_wcopy;
    logic          w_req;

    dcf_sync #(.W(2)) u_sync_to_wr (
        .clk   (wr_clk),
        .rst_n (wr_rst_n),
        .d     ({r_q.req, r_q.ack}),
        .q     ({w_req_s, w_ack_s})
    );

    dcf_sync #(.W(2)) u_sync_to_rd (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .d     ({w_q.req, w_q.ack}),
        .q     ({r_req_s, r_ack_s})
    );

    // ---------------- write domain ----------------
    always_comb begin
        w_d = w_q;
        if (wr_en) begin
            w_d.ptr = w_q.ptr + ONE;
        end
        // Sender: offer a new snapshot only when the previous exchange
        // has fully returned to idle (req low, ack low).
        if (!w_q.req && !w_ack_s && (w_q.ptr != w_q.snap)) begin
            w_d.snap = w_q.ptr;
            w_d.req  = 1'b1;
        end else if (w_q.req && w_ack_s) begin
            w_d.req = 1'b0;
        end
        // Receiver: the read-side snapshot is held stable while its req is high.
        if (w_req_s && !w_q.ack) begin
            w_d.copy = r_q.snap;
            w_d.ack  = 1'b1;
        end else if (!w_req_s && w_q.ack) begin
            w_d.ack = 1'b0;
        end
        w_used   = w_d.ptr - w_d.copy;
        w_free   = CAP - w_used;
        w_d.flag   = (w_used == CAP);
        w_d.almost = (w_free < wr_afull_lvl) && (w_used != CAP);
    end

    always_ff @(posedge wr_clk or negedge wr_rst_n) begin
        if (!wr_rst_n) begin
            w_q <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    // ---------------- read domain ----------------
    always_comb begin
        r_d = r_q;
        if (rd_en) begin
            r_d.ptr = r_q.ptr + ONE;
        end
        if (!r_q.req && !r_ack_s && (r_q.ptr != r_q.snap)) begin
            r_d.snap = r_q.ptr;
            r_d.req  = 1'b1;
        end else if (r_q.req && r_ack_s) begin
            r_d.req = 1'b0;
        end
        if (r_req_s && !r_q.ack) begin
            r_d.copy = w_q.snap;
            r_d.ack  = 1'b1;
        end else if (!r_req_s && r_q.ack) begin
            r_d.ack = 1'b0;
        end
        r_used     = r_d.copy - r_d.ptr;
        r_d.flag   = (r_used == '0);
        r_d.almost = (r_used < rd_aempty_lvl) && (r_used != '0);
    end

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) begin
            r_q      <= '0;
            r_q.flag <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    dcf_ram #(.DW(DW), .DEPTH(DEPTH), .RD_MODE(RD_MODE)) u_ram (
        .wclk   (wr_clk),
        .we     (wr_en),
        .waddr  (w_q.ptr[AW-1:0]),
        .wdata  (wr_data),
        .rclk   (rd_clk),
        .rrst_n (rd_rst_n),
        .re     (rd_en),
        .raddr  (r_q.ptr[AW-1:0]),
        .rdata  (rd_data)
    );

    assign wr_full         = w_q.flag;
    assign wr_almost_full  = w_q.almost;
    assign rd_empty        = r_q.flag;
    assign rd_almost_empty = r_q.almost;

    assign w_ptr   = w_q.ptr;
    assign w_rcopy = w_q.copy;
    assign w_snap  = w_q.snap;
    assign w_req   = w_q.req;
    assign r_ptr   = r_q.ptr;
    assign r_wcopy = r_q.copy;
endmodule

// File: rtl/dcf_chk.sv
`timescale 1ns/1ps
module dcf_chk #(
    parameter int unsigned  DEPTH = 8,
    localparam int unsigned PW    = $clog2(DEPTH) + 1
) (
    input logic          wr_clk,
    input logic          wr_rst_n,
    input logic          rd_clk,
    input logic          rd_rst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic          wr_full,
    input logic          wr_almost_full,
    input logic          rd_empty,
    input logic          rd_almost_empty,
    input logic [PW-1:0] w_ptr,
    input logic [PW-1:0] w_rcopy,
    input logic [PW-1:0] w_snap,
    input logic          w_req,
    input logic          w_ack_s,
    input logic [PW-1:0] r_ptr,
    input logic [PW-1:0] r_wcopy
);
    localparam logic [PW-1:0] CAP = PW'(DEPTH);

    logic [PW-1:0] w_cnt, r_cnt;
    assign w_cnt = w_ptr - w_rcopy;
    assign r_cnt = r_wcopy - r_ptr;

    // R3: filling the last slot raises full next edge unless a fresh copy landed.
    assert_full_next_R3: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_en && w_cnt == CAP - PW'(1)) |=> (wr_full || w_rcopy != $past(w_rcopy)));

    // R4: popping the last word raises empty next edge unless a fresh copy landed.
    assert_empty_next_R4: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_en && r_cnt == PW'(1)) |=> (rd_empty || r_wcopy != $past(r_wcopy)));

    // R5: the offered snapshot stays put until the acknowledge comes back.
    assert_snap_hold_R5: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (w_req && !w_ack_s) |=> $stable(w_snap));

    // R7: almost-full and full are never both set.
    assert_afull_excl_R7: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        !(wr_full && wr_almost_full));

    // R8: almost-empty and empty are never both set.
    assert_aempty_excl_R8: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        !(rd_empty && rd_almost_empty));

    // R10: the write side never counts more stored words than slots.
    assert_no_overflow_R10: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        w_cnt <= CAP);
endmodule

bind dcf_top dcf_chk #(.DEPTH(DEPTH)) u_chk (
    .wr_clk          (wr_clk),
    .wr_rst_n        (wr_rst_n),
    .rd_clk          (rd_clk),
    .rd_rst_n        (rd_rst_n),
    .wr_en           (wr_en),
    .rd_en           (rd_en),
    .wr_full         (wr_full),
    .wr_almost_full  (wr_almost_full),
    .rd_empty        (rd_empty),
    .rd_almost_empty (rd_almost_empty),
    .w_ptr           (w_ptr),
    .w_rcopy         (w_rcopy),
    .w_snap          (w_snap),
    .w_req           (w_req),
    .w_ack_s         (w_ack_s),
    .r_ptr           (r_ptr),
    .r_wcopy         (r_wcopy)
);

// File: tb/tb_dcf_top.sv
`timescale 1ns/1ps
module tb_dcf_top;
    import dcf_pkg::*;

    localparam int unsigned DW    = 8;
    localparam int unsigned DEPTH = 8;
    localparam int unsigned PW    = $clog2(DEPTH) + 1;
    localparam int unsigned LVL   = 3;
    localparam int          NV    = 9;
    // Table: words to write, then words to read, per step.
    localparam int VWR [NV] = '{3, 5, 0, 0, 6, 0, 1, 7, 0};
    localparam int VRD [NV] = '{0, 0, 2, 4, 1, 7, 0, 3, 5};

    logic          wr_clk = 1'b0, rd_clk = 1'b0;
    logic          wr_rst_n = 1'b0, rd_rst_n = 1'b0;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [PW-1:0] wr_afull_lvl = PW'(LVL), rd_aempty_lvl = PW'(LVL);
    logic          wr_full, wr_almost_full, rd_empty, rd_almost_empty;
    logic [DW-1:0] rd_data;
    logic          c_full, c_afull, c_empty, c_aempty;
    logic [DW-1:0] c_data;

    always #10 wr_clk = ~wr_clk;   // 50 MHz
    always #13 rd_clk = ~rd_clk;

    dcf_top #(.DW(DW), .DEPTH(DEPTH), .RD_MODE(RD_REG)) dut (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_afull_lvl(wr_afull_lvl), .wr_full(wr_full), .wr_almost_full(wr_almost_full),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_aempty_lvl(rd_aempty_lvl),
        .rd_data(rd_data), .rd_empty(rd_empty), .rd_almost_empty(rd_almost_empty)
    );

    dcf_top #(.DW(DW), .DEPTH(DEPTH), .RD_MODE(RD_COMB)) dut_c (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_afull_lvl(wr_afull_lvl), .wr_full(c_full), .wr_almost_full(c_afull),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_aempty_lvl(rd_aempty_lvl),
        .rd_data(c_data), .rd_empty(c_empty), .rd_almost_empty(c_aempty)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    logic [DW-1:0] model [64];
    int widx = 0, ridx = 0, seed = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic do_write();
        @(negedge wr_clk);
        chk(!wr_full, "R10 write slot free", wr_full, 0);
        wr_en   = 1'b1;
        wr_data = DW'(seed * 37 + 5);
        model[widx % 64] = wr_data;
        widx++;
        seed++;
        @(negedge wr_clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read();
        logic [DW-1:0] exp;
        @(negedge rd_clk);
        exp = model[ridx % 64];
        chk(!rd_empty, "R10 word available", rd_empty, 0);
        chk(c_data == exp, "R9 comb head visible", c_data, exp);
        rd_en = 1'b1;
        ridx++;
        @(negedge rd_clk);
        rd_en = 1'b0;
        chk(rd_data == exp, "R2 order and value", rd_data, exp);
    endtask

    task automatic settle();
        repeat (14) @(negedge wr_clk);
        repeat (14) @(negedge rd_clk);
    endtask

    task automatic check_flags();
        int cnt;
        cnt = widx - ridx;
        chk(wr_full == (cnt == DEPTH), "R3 settled full", wr_full, cnt == DEPTH);
        chk(rd_empty == (cnt == 0), "R4 settled empty", rd_empty, cnt == 0);
        chk(wr_almost_full == ((DEPTH - cnt) < LVL && cnt != DEPTH),
            "R7 almost full", wr_almost_full, (DEPTH - cnt) < LVL && cnt != DEPTH);
        chk(rd_almost_empty == (cnt < LVL && cnt != 0),
            "R8 almost empty", rd_almost_empty, cnt < LVL && cnt != 0);
    endtask

    task automatic check_reset_flags(input string tag);
        chk(rd_empty == 1'b1, tag, rd_empty, 1);
        chk(rd_almost_empty == 1'b0, tag, rd_almost_empty, 0);
        chk(wr_full == 1'b0, tag, wr_full, 0);
        chk(wr_almost_full == 1'b0, tag, wr_almost_full, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge wr_clk);
        if (!done) begin
            chk(1'b0, "R10 watchdog expired", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        int n;
        // R1: reset state, during and after reset
        repeat (3) @(negedge wr_clk);
        check_reset_flags("R1 in reset");
        wr_rst_n = 1'b1;
        rd_rst_n = 1'b1;
        settle();
        check_reset_flags("R1 after reset");

        // Table walk: R2, R7, R8 over several fill levels, with pointer wrap
        for (int i = 0; i < NV; i++) begin
            for (int k = 0; k < VWR[i]; k++) do_write();
            for (int k = 0; k < VRD[i]; k++) do_read();
            settle();
            check_flags();
        end

        // R6 then R4: write into empty, then read the only word
        do_write();
        @(negedge rd_clk);
        chk(rd_empty == 1'b1, "R6 empty held after remote write", rd_empty, 1);
        n = 1;
        while (rd_empty && n < 40) begin
            @(negedge rd_clk);
            n++;
        end
        chk(!rd_empty && n <= 12, "R6 empty clears in time", n, 12);
        do_read();
        chk(rd_empty == 1'b1, "R4 empty next read edge", rd_empty, 1);
        settle();

        // R3 then R5: fill to DEPTH-1, add the last word, then free one slot
        for (int k = 0; k < DEPTH - 1; k++) do_write();
        settle();
        chk(wr_full == 1'b0, "R3 not full one short", wr_full, 0);
        do_write();
        chk(wr_full == 1'b1, "R3 full next write edge", wr_full, 1);
        do_read();
        @(negedge wr_clk);
        chk(wr_full == 1'b1, "R5 full held after remote read", wr_full, 1);
        n = 1;
        while (wr_full && n < 40) begin
            @(negedge wr_clk);
            n++;
        end
        chk(!wr_full && n <= 12, "R5 full clears in time", n, 12);
        while (widx != ridx) do_read();
        settle();
        check_flags();

        // R10: continuous concurrent streaming, each side gated by its own flag
        fork
            begin : wr_stream
                int sent;
                sent = 0;
                while (sent < 40) begin
                    @(negedge wr_clk);
                    if (!wr_full) begin
                        wr_en   = 1'b1;
                        wr_data = DW'(seed * 37 + 5);
                        model[widx % 64] = wr_data;
                        widx++;
                        seed++;
                        sent++;
                    end else begin
                        wr_en = 1'b0;
                    end
                end
                @(negedge wr_clk);
                wr_en = 1'b0;
            end
            begin : rd_stream
                int got;
                bit pend;
                logic [DW-1:0] prev;
                got  = 0;
                pend = 1'b0;
                prev = '0;
                while (got < 40) begin
                    @(negedge rd_clk);
                    if (pend) chk(rd_data == prev, "R10 stream data", rd_data, prev);
                    pend = 1'b0;
                    if (!rd_empty) begin
                        prev = model[ridx % 64];
                        chk(c_data == prev, "R9 comb stream head", c_data, prev);
                        rd_en = 1'b1;
                        ridx++;
                        got++;
                        pend = 1'b1;
                    end else begin
                        rd_en = 1'b0;
                    end
                end
                @(negedge rd_clk);
                rd_en = 1'b0;
                if (pend) chk(rd_data == prev, "R10 stream last", rd_data, prev);
            end
        join
        settle();
        check_flags();

        // R1: reset with data stored returns to the empty state
        for (int k = 0; k < 3; k++) do_write();
        settle();
        @(negedge wr_clk);
        wr_rst_n = 1'b0;
        rd_rst_n = 1'b0;
        repeat (3) @(negedge rd_clk);
        check_reset_flags("R1 mid-run reset");
        wr_rst_n = 1'b1;
        rd_rst_n = 1'b1;
        widx = 0;
        ridx = 0;
        settle();
        check_reset_flags("R1 after mid-run reset");
        do_write();
        settle();
        do_read();
        check_flags();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule